// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the byte-wide, two-address programming front end of a classic eight-input priority interrupt controller. Software writes configuration words and run-time commands through two addresses. The block decodes them, walks the multi-word initialisation sequence, and holds the resulting mode flags, vector base and mask register. It sends one-cycle command strobes (end-of-interrupt, rotate, set priority) to a separate priority resolver. That resolver is outside this block.

On reads, the block returns the resolver's pending or in-service vector, or the mask, depending on the address and the register-select flag. A poll read returns the resolver's current winner and raises a clear strobe so the resolver can drop that request. Every write takes effect on the next clock edge. Read data and the poll clear strobe are combinational while the read strobe is high.

Top module: `pic_cmd_seq`

## Requirements
- R1: After reset the sequencer is in normal mode. The mask, vector base, auto-EOI, special nested, special mask, rotate-on-auto-EOI, poll and all strobes are 0, and register select is 0, so an address-0 read returns `pend_i`.
- R2: An address-0 write with bit 4 set clears the mask, vector base, all mode flags, register select and poll. It latches the four-word flag from bit 0 and the single flag from bit 1, enters the vector step, and pulses `int_kill_o` for one cycle.
- R3: In the vector step, an address-1 write loads `vec_base_o` from data bits 7:3. The next step is the cascade step when single is 0. When single is 1, the next step is the mode step if the four-word flag is set, and normal mode otherwise.
- R4: In the cascade step, an address-1 write is consumed without changing any output. The next step is the mode step if the four-word flag is set, and normal mode otherwise.
- R5: In the mode step, an address-1 write sets `nest_o` from bit 4 and `aeoi_o` from bit 1, then returns to normal mode.
- R6: An address-1 write loads the mask only in normal mode. In any sequence step the mask is left unchanged.
- R7: An address-0 write with bits 4:3 = 01 is a control command. Bit 2 arms poll. Bit 1 enables loading register select from bit 0. Bit 6 enables loading special mask from bit 5.
- R8: An address-0 write with bits 4:3 = 00 decodes bits 7:5. Code 0 clears `rot_aeoi_o`, code 4 sets it, and code 2 changes nothing.
- R9: One cycle after a write with bits 4:3 = 00, the strobes pulse for one cycle:
  - code 1: `eoi_o`
  - code 5: `eoi_o` and `rot_o`
  - code 3: `eoi_o` and `spec_o`
  - code 7: `eoi_o`, `spec_o` and `rot_o`
  - code 6: `prio_o`
  
  `lvl_o` carries data bits 2:0 of that write.
- R10: A non-poll read at address 0 returns `insvc_i` when register select is 1 and `pend_i` when it is 0. A read at address 1 returns the mask.
- R11: A read with poll armed returns {5'b0, `poll_idx_i`} and asserts `poll_clr_o` when `poll_hit_i` is 1. It returns 8'h07 with `poll_clr_o` low when `poll_hit_i` is 0. Poll is disarmed from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 1 | Register address |
| wdata_i | input | 8 | Write data |
| pend_i | input | 8 | Pending vector from resolver |
| insvc_i | input | 8 | In-service vector from resolver |
| poll_hit_i | input | 1 | Resolver has a winner |
| poll_idx_i | input | 3 | Index of the winner |
| rdata_o | output | 8 | Read data |
| poll_clr_o | output | 1 | Clear the winner's pending and in-service bits |
| vec_base_o | output | 5 | Vector base, upper bits |
| aeoi_o | output | 1 | Auto end-of-interrupt mode |
| nest_o | output | 1 | Special fully nested mode |
| smask_o | output | 1 | Special mask mode |
| rot_aeoi_o | output | 1 | Rotate on auto end-of-interrupt |
| mask_o | output | 8 | Mask register |
| eoi_o | output | 1 | End-of-interrupt strobe |
| spec_o | output | 1 | End-of-interrupt targets `lvl_o` |
| rot_o | output | 1 | Rotate priority after end-of-interrupt |
| prio_o | output | 1 | Set lowest priority to `lvl_o` |
| lvl_o | output | 3 | Level field of the last command |
| int_kill_o | output | 1 | Deassert interrupt output on initialisation |

## Verification
The assertions check three things on every cycle:
- an initialisation word always lands in the vector step;
- the mask and mode flags move only on the write that is allowed to change them;
- every strobe traces back to a command write the cycle before, and poll disarms after a poll read.

Only the bench's scenarios can show the exact path through the sequence steps for each combination of single and four-word flags. The same holds for the read-select and special-mask gating by their enable bits and the full command-code table. The bench's reference model checks these on every clock.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
  typedef enum logic [1:0] {
    ST_NORM = 2'd0,
    ST_VEC  = 2'd1,
    ST_CASC = 2'd2,
    ST_MODE = 2'd3
  } step_e;

  typedef enum logic [2:0] {
    OP_RAE_CLR = 3'd0,
    OP_EOI     = 3'd1,
    OP_NOP     = 3'd2,
    OP_EOI_SP  = 3'd3,
    OP_RAE_SET = 3'd4,
    OP_EOI_ROT = 3'd5,
    OP_PRIO    = 3'd6,
    OP_SP_ROT  = 3'd7
  } op_e;
endpackage

// File: rtl/pic_icw_seq.sv
module pic_icw_seq
  import pic_cmd_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned LVLW = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               icw_start_i,
  input  logic               wr1_i,
  input  logic [DW-1:0]      wdata_i,
  output logic               normal_o,
  output logic [DW-LVLW-1:0] vec_o,
  output logic               aeoi_o,
  output logic               nest_o
);
  step_e              step_q;
  logic               four_q, single_q;
  logic [DW-LVLW-1:0] vec_q;
  logic               aeoi_q, nest_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q   <= ST_NORM;
      four_q   <= 1'b0;
      single_q <= 1'b0;
      vec_q    <= '0;
      aeoi_q   <= 1'b0;
      nest_q   <= 1'b0;
    end else if (icw_start_i) begin
      step_q   <= ST_VEC;
      four_q   <= wdata_i[0];
      single_q <= wdata_i[1];
      vec_q    <= '0;
      aeoi_q   <= 1'b0;
      nest_q   <= 1'b0;
    end else if (wr1_i) begin
      unique case (step_q)
        ST_VEC: begin
          vec_q  <= wdata_i[DW-1:LVLW];
          step_q <= !single_q ? ST_CASC : (four_q ? ST_MODE : ST_NORM);
        end
        ST_CASC: step_q <= four_q ? ST_MODE : ST_NORM;  // cascade word dropped
        ST_MODE: begin
          nest_q <= wdata_i[4];
          aeoi_q <= wdata_i[1];
          step_q <= ST_NORM;
        end
        default: ;
      endcase
    end
  end

  assign normal_o = (step_q == ST_NORM);
  assign vec_o    = vec_q;
  assign aeoi_o   = aeoi_q;
  assign nest_o   = nest_q;

  p_start_vec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    icw_start_i |=> (step_q == ST_VEC));
  p_mode_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!icw_start_i && !(wr1_i && step_q == ST_MODE)) |=> ($stable(aeoi_q) && $stable(nest_q)));
  p_vec_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!icw_start_i && !(wr1_i && step_q == ST_VEC)) |=> $stable(vec_q));
endmodule

// File: rtl/pic_ocw_dec.sv
module pic_ocw_dec
  import pic_cmd_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned LVLW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            icw_start_i,
  input  logic            ocw2_i,
  input  logic            ocw3_i,
  input  logic            poll_rd_i,
  input  logic [DW-1:0]   wdata_i,
  output logic            poll_o,
  output logic            rsel_o,
  output logic            smask_o,
  output logic            rot_aeoi_o,
  output logic            eoi_o,
  output logic            spec_o,
  output logic            rot_o,
  output logic            prio_o,
  output logic [LVLW-1:0] lvl_o
);
  op_e op;
  assign op = op_e'(wdata_i[7:5]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      poll_o     <= 1'b0;
      rsel_o     <= 1'b0;
      smask_o    <= 1'b0;
      rot_aeoi_o <= 1'b0;
      eoi_o      <= 1'b0;
      spec_o     <= 1'b0;
      rot_o      <= 1'b0;
      prio_o     <= 1'b0;
      lvl_o      <= '0;
    end else begin
      eoi_o  <= 1'b0;
      spec_o <= 1'b0;
      rot_o  <= 1'b0;
      prio_o <= 1'b0;
      if (icw_start_i) begin
        poll_o     <= 1'b0;
        rsel_o     <= 1'b0;
        smask_o    <= 1'b0;
        rot_aeoi_o <= 1'b0;
      end else if (ocw3_i) begin
        if (wdata_i[2]) poll_o <= 1'b1;
        else if (poll_rd_i) poll_o <= 1'b0;
        if (wdata_i[1]) rsel_o  <= wdata_i[0];
        if (wdata_i[6]) smask_o <= wdata_i[5];
      end else begin
        if (poll_rd_i) poll_o <= 1'b0;
        if (ocw2_i) begin
          lvl_o <= wdata_i[LVLW-1:0];
          unique case (op)
            OP_RAE_CLR: rot_aeoi_o <= 1'b0;
            OP_RAE_SET: rot_aeoi_o <= 1'b1;
            OP_EOI:     eoi_o <= 1'b1;
            OP_EOI_ROT: begin eoi_o <= 1'b1; rot_o <= 1'b1; end
            OP_EOI_SP:  begin eoi_o <= 1'b1; spec_o <= 1'b1; end
            OP_SP_ROT:  begin eoi_o <= 1'b1; spec_o <= 1'b1; rot_o <= 1'b1; end
            OP_PRIO:    prio_o <= 1'b1;
            default:    ;
          endcase
        end
      end
    end
  end

  p_strobe_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_o || prio_o) |-> $past(ocw2_i));
  p_poll_drop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_rd_i && !ocw3_i) |=> !poll_o);
  p_ctrl_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ocw3_i && !icw_start_i) |=> ($stable(rsel_o) && $stable(smask_o)));
endmodule

// File: rtl/pic_rd_mux.sv
module pic_rd_mux #(
  parameter int unsigned DW   = 8,
  parameter int unsigned LVLW = 3
) (
  input  logic            rd_i,
  input  logic            addr_i,
  input  logic            poll_i,
  input  logic            rsel_i,
  input  logic [DW-1:0]   pend_i,
  input  logic [DW-1:0]   insvc_i,
  input  logic [DW-1:0]   mask_i,
  input  logic            hit_i,
  input  logic [LVLW-1:0] idx_i,
  output logic [DW-1:0]   rdata_o,
  output logic            poll_clr_o
);
  localparam logic [DW-1:0] NO_WIN = DW'(7);

  always_comb begin
    poll_clr_o = 1'b0;
    if (rd_i && poll_i) begin
      rdata_o    = hit_i ? DW'(idx_i) : NO_WIN;
      poll_clr_o = hit_i;
    end else if (addr_i) begin
      rdata_o = mask_i;
    end else begin
      rdata_o = rsel_i ? insvc_i : pend_i;
    end
  end

  always_comb begin
    if (poll_clr_o) a_clr_rd_r11: assert (rd_i && hit_i);
  end
endmodule

// File: rtl/pic_cmd_seq.sv
module pic_cmd_seq #(
  parameter int unsigned DW   = 8,
  parameter int unsigned LVLW = $clog2(DW)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic               addr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [DW-1:0]      pend_i,
  input  logic [DW-1:0]      insvc_i,
  input  logic               poll_hit_i,
  input  logic [LVLW-1:0]    poll_idx_i,
  output logic [DW-1:0]      rdata_o,
  output logic               poll_clr_o,
  output logic [DW-LVLW-1:0] vec_base_o,
  output logic               aeoi_o,
  output logic               nest_o,
  output logic               smask_o,
  output logic               rot_aeoi_o,
  output logic [DW-1:0]      mask_o,
  output logic               eoi_o,
  output logic               spec_o,
  output logic               rot_o,
  output logic               prio_o,
  output logic [LVLW-1:0]    lvl_o,
  output logic               int_kill_o
);
  logic wr0, wr1, icw_start, ocw2, ocw3, normal, poll, rsel, poll_rd;
  logic [DW-1:0] mask_q;
  logic          kill_q;

  assign wr0       = wr_i && !addr_i;
  assign wr1       = wr_i && addr_i;
  assign icw_start = wr0 && wdata_i[4];
  assign ocw3      = wr0 && !wdata_i[4] && wdata_i[3];
  assign ocw2      = wr0 && !wdata_i[4] && !wdata_i[3];
  assign poll_rd   = rd_i && poll;

  pic_icw_seq #(.DW(DW), .LVLW(LVLW)) u_icw (
    .clk_i, .rst_ni, .icw_start_i(icw_start), .wr1_i(wr1), .wdata_i,
    .normal_o(normal), .vec_o(vec_base_o), .aeoi_o, .nest_o
  );

  pic_ocw_dec #(.DW(DW), .LVLW(LVLW)) u_ocw (
    .clk_i, .rst_ni, .icw_start_i(icw_start), .ocw2_i(ocw2), .ocw3_i(ocw3),
    .poll_rd_i(poll_rd), .wdata_i, .poll_o(poll), .rsel_o(rsel), .smask_o,
    .rot_aeoi_o, .eoi_o, .spec_o, .rot_o, .prio_o, .lvl_o
  );

  pic_rd_mux #(.DW(DW), .LVLW(LVLW)) u_rd (
    .rd_i, .addr_i, .poll_i(poll), .rsel_i(rsel), .pend_i, .insvc_i,
    .mask_i(mask_q), .hit_i(poll_hit_i), .idx_i(poll_idx_i),
    .rdata_o, .poll_clr_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      kill_q <= 1'b0;
    end else begin
      kill_q <= icw_start;
      if (icw_start)           mask_q <= '0;
      else if (wr1 && normal)  mask_q <= wdata_i;
    end
  end

  assign mask_o     = mask_q;
  assign int_kill_o = kill_q;

  p_mask_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr1 && normal) && !icw_start |=> $stable(mask_q));
  p_kill_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_kill_o |-> (mask_q == '0 && vec_base_o == '0 && !aeoi_o && !nest_o));
endmodule

// File: tb/sim_pic_cmd_seq.sv
module sim_pic_cmd_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0, rd = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0, pend = '0, insvc = '0;
  logic       hit = 1'b0;
  logic [2:0] idx = '0;
  logic [7:0] rdata, mask;
  logic       pclr, aeoi, nest, smask, rotae, eoi, spec, rot, prio, kill;
  logic [4:0] vec;
  logic [2:0] lvl;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference state
  int m_step = 0, m_four = 0, m_single = 0, m_vec = 0, m_mask = 0;
  int m_aeoi = 0, m_nest = 0, m_smask = 0, m_rsel = 0, m_poll = 0, m_rotae = 0;
  int m_eoi = 0, m_spec = 0, m_rot = 0, m_prio = 0, m_lvl = 0, m_kill = 0;

  always #5 clk = ~clk;

  pic_cmd_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .pend_i(pend), .insvc_i(insvc), .poll_hit_i(hit),
    .poll_idx_i(idx), .rdata_o(rdata), .poll_clr_o(pclr), .vec_base_o(vec),
    .aeoi_o(aeoi), .nest_o(nest), .smask_o(smask), .rot_aeoi_o(rotae),
    .mask_o(mask), .eoi_o(eoi), .spec_o(spec), .rot_o(rot), .prio_o(prio),
    .lvl_o(lvl), .int_kill_o(kill)
  );

  task automatic chk(input string req, input string nm, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, nm, act, exp);
    end
  endtask

  task automatic chk_regs();
    chk("R3", "vec", vec, m_vec);
    chk("R6", "mask", mask, m_mask);
    chk("R5", "aeoi", aeoi, m_aeoi);
    chk("R5", "nest", nest, m_nest);
    chk("R7", "smask", smask, m_smask);
    chk("R8", "rot_aeoi", rotae, m_rotae);
    chk("R9", "eoi", eoi, m_eoi);
    chk("R9", "spec", spec, m_spec);
    chk("R9", "rot", rot, m_rot);
    chk("R9", "prio", prio, m_prio);
    if (m_eoi != 0 || m_prio != 0) chk("R9", "lvl", lvl, m_lvl);
    chk("R2", "int_kill", kill, m_kill);
  endtask

  task automatic model_edge(input bit w, input bit r, input bit a, input int d);
    m_eoi = 0; m_spec = 0; m_rot = 0; m_prio = 0; m_kill = 0;
    if (w && !a && d[4]) begin
      m_step = 1; m_four = d[0]; m_single = d[1];
      m_vec = 0; m_mask = 0; m_aeoi = 0; m_nest = 0;
      m_smask = 0; m_rsel = 0; m_poll = 0; m_rotae = 0; m_kill = 1;
    end else if (w && !a && d[3]) begin
      if (d[2]) m_poll = 1;
      if (d[1]) m_rsel = d[0];
      if (d[6]) m_smask = d[5];
    end else if (w && !a) begin
      m_lvl = d & 7;
      case ((d >> 5) & 7)
        0: m_rotae = 0;
        4: m_rotae = 1;
        1: m_eoi = 1;
        5: begin m_eoi = 1; m_rot = 1; end
        3: begin m_eoi = 1; m_spec = 1; end
        7: begin m_eoi = 1; m_spec = 1; m_rot = 1; end
        6: m_prio = 1;
        default: ;
      endcase
    end else if (w && a) begin
      case (m_step)
        0: m_mask = d & 255;
        1: begin
          m_vec = (d >> 3) & 31;
          m_step = (m_single == 0) ? 2 : (m_four != 0 ? 3 : 0);
        end
        2: m_step = (m_four != 0) ? 3 : 0;
        default: begin m_nest = d[4]; m_aeoi = d[1]; m_step = 0; end
      endcase
    end
    if (r && m_poll != 0) m_poll = 0;
  endtask

  // one bus cycle: drive after negedge, check comb outputs, clock, check regs
  task automatic cyc(input bit w, input bit r, input bit a, input int d);
    int exp_rd, exp_clr;
    wr = w; rd = r; addr = a; wdata = d[7:0];
    #1;
    exp_clr = 0;
    if (r && m_poll != 0) begin
      exp_rd = hit ? int'(idx) : 7;
      exp_clr = hit;
      chk("R11", "poll_rdata", rdata, exp_rd);
    end else if (r) begin
      exp_rd = a ? m_mask : (m_rsel != 0 ? int'(insvc) : int'(pend));
      chk("R10", "rdata", rdata, exp_rd);
    end
    chk("R11", "poll_clr", pclr, exp_clr);
    @(posedge clk);
    model_edge(w, r, a, d);
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
    chk_regs();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    pend = 8'h5A; insvc = 8'hC3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk_regs();
    cyc(0, 1, 0, 0);   // R1 pending read with select 0
    cyc(0, 1, 1, 0);   // R1 mask 0

    // R2 R3 R4 R5: full sequence, not single, four-word
    cyc(1, 0, 1, 8'hFF);          // R6 normal mask load
    cyc(1, 0, 0, 8'h11);
    cyc(1, 0, 1, 8'hAA);          // R6 mask ignored here, vector loaded
    cyc(1, 0, 1, 8'hFF);          // R4 cascade word consumed
    cyc(1, 0, 1, 8'h12);          // R5 nest=1 aeoi=1
    cyc(1, 0, 1, 8'hA5);
    cyc(0, 1, 1, 0);

    // single, no four-word: straight back to normal
    cyc(1, 0, 0, 8'h12);
    cyc(1, 0, 1, 8'hF0);
    cyc(1, 0, 1, 8'h3C);
    // single with four-word
    cyc(1, 0, 0, 8'h13);
    cyc(1, 0, 1, 8'h08);
    cyc(1, 0, 1, 8'h02);
    // not single, no four-word
    cyc(1, 0, 0, 8'h10);
    cyc(1, 0, 1, 8'h78);
    cyc(1, 0, 1, 8'h55);
    cyc(1, 0, 1, 8'h81);

    // R7 control commands and R10 read select
    cyc(1, 0, 0, 8'h0B); cyc(0, 1, 0, 0);
    cyc(1, 0, 0, 8'h09); cyc(0, 1, 0, 0);   // enable clear: select stays
    cyc(1, 0, 0, 8'h0A); cyc(0, 1, 0, 0);
    cyc(1, 0, 0, 8'h68); cyc(1, 0, 0, 8'h28); cyc(1, 0, 0, 8'h48);

    // R8 R9 all command codes
    for (int c = 0; c < 8; c++) cyc(1, 0, 0, (c << 5) | (7 - c));
    cyc(1, 0, 0, 8'h80); cyc(1, 0, 0, 8'h40);   // R8 code 2 keeps rot_aeoi

    // R11 poll
    hit = 1'b1; idx = 3'd5;
    cyc(1, 0, 0, 8'h0C); cyc(0, 1, 0, 0); cyc(0, 1, 0, 0);
    hit = 1'b0;
    cyc(1, 0, 0, 8'h0C); cyc(0, 1, 1, 0); cyc(0, 1, 1, 0);

    // R2 initialisation clears live modes
    cyc(1, 0, 0, 8'h6B); cyc(1, 0, 0, 8'h80);
    cyc(1, 0, 0, 8'h13);

    for (int i = 0; i < 400; i++) begin
      int k;
      k = $urandom_range(0, 5);
      pend = 8'($urandom); insvc = 8'($urandom);
      hit = 1'($urandom); idx = 3'($urandom);
      case (k)
        0: cyc(0, 1, 1'($urandom), 0);
        1: cyc(1, 0, 1, int'($urandom_range(0, 255)));
        2: cyc(1, 0, 0, int'($urandom_range(0, 255)) & 8'hE7);
        3: cyc(1, 0, 0, (int'($urandom_range(0, 255)) & 8'hE7) | 8'h08);
        4: cyc(1, 0, 0, int'($urandom_range(0, 15)) | 8'h10);
        default: cyc(0, 0, 0, 0);
      endcase
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule